// File: doc/BRIEF.md
# Virtual-to-Physical Lookup Unit with Data Byte Return

This unit turns a 14-bit virtual address into a data byte. A small set-associative translation buffer is consulted first. When it misses, a 256-entry page table held in flops supplies the frame number. If that entry is also invalid, the request is reported as a fault. The 12-bit physical address that results selects one line of a direct-mapped, physically addressed data cache. The response reports each stage on its own: whether the translation buffer hit, whether a fault occurred, the physical address, whether the cache hit, and the byte returned.

A miss that the page table resolves copies its translation into the translation buffer. The buffer, the page table and the cache are all filled through dedicated load ports. Refilling the cache from memory and handling faults are left to the surrounding system; this unit only reports them. Every request takes exactly two cycles and produces a single-cycle response.

Top module: `xlate_lookup`

## Requirements
- R1: The page offset is VA[5:0] and the page number is VA[13:6]. For any response without a fault, rsp_pa equals {frame number, VA[5:0]}.
- R2: The translation buffer has 4 sets of 4 ways. The set is VA[7:6] and the tag is VA[13:8]. rsp_tlb_hit is 1 only when a valid way in that set holds that tag, and the frame then comes from that way.
- R3: On a buffer miss, the page-table entry indexed by VA[13:6] is read. When that entry is valid, its frame is used and rsp_fault is 0.
- R4: A buffer miss on an invalid page-table entry gives rsp_fault=1 with rsp_tlb_hit=0, rsp_pa=0, rsp_cache_hit=0 and rsp_byte=0. The buffer is not changed, so repeating the request faults again.
- R5: The cache line is PA[5:2] and the cache tag is PA[11:6]. A hit needs a valid line with an equal tag, and then rsp_byte is byte PA[1:0] of the 32-bit block (byte 0 in bits 7:0). A miss returns rsp_byte=0.
- R6: A miss that the page table resolves installs the translation in the indexed set, in the lowest-numbered invalid way. The next request to that page hits, including a request issued in the very next cycle.
- R7: In a full set, the victim is chosen by a per-set round-robin pointer. The pointer starts at way 0 after reset and advances by one after each replacement in a full set.
- R8: When a buffer load-port write targets the same set as an install in the same cycle, the write takes effect and the install is dropped, and the pointer does not move. When the sets differ, both take effect.
- R9: A request in cycle t gives rsp_valid=1 in cycle t+2 for exactly one cycle per request. All response outputs are 0 while rsp_valid is 0.
- R10: After reset, all buffer, page-table and cache entries are invalid, and rsp_valid is 0.
- R11: With set 3 holding tag 0x03 → frame 0x0D, page 0x00 → frame 0x28, line 5 holding tag 0x0D with byte 0 = 0x36, and line 8 holding tag 0x24: VA 0x03D4 hits and gives PA 0x354 and byte 0x36. VA 0x0020 misses in the buffer, does not fault, and gives PA 0xA20 and a cache miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 14 | Virtual address |
| tlb_ld_en | input | 1 | Write one translation-buffer way |
| tlb_ld_set | input | 2 | Set written |
| tlb_ld_way | input | 2 | Way written |
| tlb_ld_valid | input | 1 | Valid bit written |
| tlb_ld_tag | input | 6 | Tag written |
| tlb_ld_ppn | input | 6 | Frame number written |
| pt_ld_en | input | 1 | Write one page-table entry |
| pt_ld_vpn | input | 8 | Page-table index |
| pt_ld_valid | input | 1 | Valid bit written |
| pt_ld_ppn | input | 6 | Frame number written |
| dc_ld_en | input | 1 | Write one cache line |
| dc_ld_line | input | 4 | Line index |
| dc_ld_valid | input | 1 | Valid bit written |
| dc_ld_tag | input | 6 | Tag written |
| dc_ld_data | input | 32 | Block written, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response strobe |
| rsp_tlb_hit | output | 1 | Translation buffer hit |
| rsp_fault | output | 1 | Page fault |
| rsp_pa | output | 12 | Physical address |
| rsp_cache_hit | output | 1 | Data cache hit |
| rsp_byte | output | 8 | Returned byte |

## Verification
Two functions can land on the same clock edge: an install caused by a resolved miss, and a load-port write to the translation buffer. The bench provokes this by issuing a missing request together with a load-port write, once to the same set and once to a different set. It then judges the outcome by follow-up lookups: the written tag must hit, and the dropped install must show up as a miss on the requested page. A second pair is a miss followed by a request to the same page in the next cycle, which must already hit.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W      = 14;
  localparam int PA_W      = 12;
  localparam int PG_OFF_W  = 6;
  localparam int VPN_W     = VA_W - PG_OFF_W;
  localparam int PPN_W     = PA_W - PG_OFF_W;
  localparam int TLB_SET_W = 2;
  localparam int TLB_WAY_W = 2;
  localparam int TLB_SETS  = 1 << TLB_SET_W;
  localparam int TLB_WAYS  = 1 << TLB_WAY_W;
  localparam int TLB_TAG_W = VPN_W - TLB_SET_W;
  localparam int PT_DEPTH  = 1 << VPN_W;
  localparam int BYTE_W    = 8;
  localparam int BLK_OFF_W = 2;
  localparam int BLK_BITS  = BYTE_W << BLK_OFF_W;
  localparam int LINE_W    = 4;
  localparam int LINES     = 1 << LINE_W;
  localparam int CTAG_W    = PA_W - LINE_W - BLK_OFF_W;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb import xlate_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [VPN_W-1:0]     lk_vpn,
  output logic                 lk_hit,
  output logic [PPN_W-1:0]     lk_ppn,
  input  logic                 ins_en,
  input  logic [PPN_W-1:0]     ins_ppn,
  input  logic                 ld_en,
  input  logic [TLB_SET_W-1:0] ld_set,
  input  logic [TLB_WAY_W-1:0] ld_way,
  input  logic                 ld_valid,
  input  logic [TLB_TAG_W-1:0] ld_tag,
  input  logic [PPN_W-1:0]     ld_ppn
);
  logic                 v_w [TLB_SETS][TLB_WAYS];
  logic [TLB_TAG_W-1:0] t_w [TLB_SETS][TLB_WAYS];
  logic [PPN_W-1:0]     p_w [TLB_SETS][TLB_WAYS];
  logic [TLB_WAY_W-1:0] rr_w [TLB_SETS];

  logic [TLB_SET_W-1:0] set_idx;
  logic [TLB_TAG_W-1:0] tag_in;
  logic                 set_full;
  logic [TLB_WAY_W-1:0] first_inv;
  logic [TLB_WAY_W-1:0] victim;
  logic                 ins_fire;

  assign set_idx = lk_vpn[TLB_SET_W-1:0];
  assign tag_in  = lk_vpn[VPN_W-1:TLB_SET_W];

  // lookup: lowest matching way supplies the frame
  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int w = TLB_WAYS-1; w >= 0; w--) begin
      if (v_w[set_idx][w] && (t_w[set_idx][w] == tag_in)) begin
        lk_hit = 1'b1;
        lk_ppn = p_w[set_idx][w];
      end
    end
  end

  // victim choice: lowest invalid way, else the set's round-robin pointer
  always_comb begin
    set_full  = 1'b1;
    first_inv = '0;
    for (int w = TLB_WAYS-1; w >= 0; w--) begin
      if (!v_w[set_idx][w]) begin
        set_full  = 1'b0;
        first_inv = TLB_WAY_W'(w);
      end
    end
    victim = set_full ? rr_w[set_idx] : first_inv;
  end

  // a load-port write into the same set suppresses the install
  assign ins_fire = ins_en && !(ld_en && (ld_set == set_idx));

  for (genvar s = 0; s < TLB_SETS; s++) begin : g_set
    logic [TLB_WAY_W-1:0] rr_q, rr_d;
    always_comb begin
      rr_d = rr_q;
      if (ins_fire && set_full && (set_idx == TLB_SET_W'(s)))
        rr_d = rr_q + TLB_WAY_W'(1);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rr_q <= '0;
      else        rr_q <= rr_d;
    end
    assign rr_w[s] = rr_q;

    for (genvar w = 0; w < TLB_WAYS; w++) begin : g_way
      logic                 we_ld, we_in, v_q, v_d;
      logic [TLB_TAG_W-1:0] t_q;
      logic [PPN_W-1:0]     p_q;
      assign we_ld = ld_en && (ld_set == TLB_SET_W'(s)) && (ld_way == TLB_WAY_W'(w));
      assign we_in = ins_fire && (set_idx == TLB_SET_W'(s)) && (victim == TLB_WAY_W'(w));
      always_comb begin
        v_d = v_q;
        if (we_ld)      v_d = ld_valid;
        else if (we_in) v_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_d;
      end
      always_ff @(posedge clk) begin
        if (we_ld) begin
          t_q <= ld_tag;
          p_q <= ld_ppn;
        end else if (we_in) begin
          t_q <= tag_in;
          p_q <= ins_ppn;
        end
      end
      assign v_w[s][w] = v_q;
      assign t_w[s][w] = t_q;
      assign p_w[s][w] = p_q;
    end
  end

  assert_install_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |=> (v_w[$past(set_idx)][$past(victim)] &&
                  (t_w[$past(set_idx)][$past(victim)] == $past(tag_in))));

  assert_fill_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && !set_full) |-> !v_w[set_idx][victim]);

  assert_rr_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && set_full) |=> (rr_w[$past(set_idx)] != $past(rr_w[set_idx])));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ins_en && (ld_set == set_idx)) |=>
      ((t_w[$past(ld_set)][$past(ld_way)] == $past(ld_tag)) &&
       (v_w[$past(ld_set)][$past(ld_way)] == $past(ld_valid))));
endmodule

// File: rtl/xlate_ptab.sv
module xlate_ptab import xlate_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             rd_valid,
  output logic [PPN_W-1:0] rd_ppn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_valid,
  input  logic [PPN_W-1:0] wr_ppn
);
  logic             pv_q [PT_DEPTH];
  logic [PPN_W-1:0] pp_q [PT_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PT_DEPTH; i++) pv_q[i] <= 1'b0;
    end else if (wr_en) begin
      pv_q[wr_vpn] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) pp_q[wr_vpn] <= wr_ppn;
  end

  assign rd_valid = pv_q[rd_vpn];
  assign rd_ppn   = pp_q[rd_vpn];

  assert_pt_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pv_q[$past(wr_vpn)] == $past(wr_valid)));
endmodule

// File: rtl/xlate_dcache.sv
module xlate_dcache import xlate_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PA_W-1:0]     rd_pa,
  output logic                rd_hit,
  output logic [BYTE_W-1:0]   rd_byte,
  input  logic                wr_en,
  input  logic [LINE_W-1:0]   wr_line,
  input  logic                wr_valid,
  input  logic [CTAG_W-1:0]   wr_tag,
  input  logic [BLK_BITS-1:0] wr_data
);
  logic                cv_q [LINES];
  logic [CTAG_W-1:0]   ct_q [LINES];
  logic [BLK_BITS-1:0] cd_q [LINES];

  logic [BLK_OFF_W-1:0] boff;
  logic [LINE_W-1:0]    line;
  logic [CTAG_W-1:0]    ptag;
  logic [BLK_BITS-1:0]  blk;

  assign boff = rd_pa[BLK_OFF_W-1:0];
  assign line = rd_pa[BLK_OFF_W +: LINE_W];
  assign ptag = rd_pa[PA_W-1 -: CTAG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) cv_q[i] <= 1'b0;
    end else if (wr_en) begin
      cv_q[wr_line] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ct_q[wr_line] <= wr_tag;
      cd_q[wr_line] <= wr_data;
    end
  end

  assign blk     = cd_q[line];
  assign rd_hit  = cv_q[line] && (ct_q[line] == ptag);
  assign rd_byte = blk[{boff, 3'b000} +: BYTE_W];

  assert_line_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((cv_q[$past(wr_line)] == $past(wr_valid)) &&
               (ct_q[$past(wr_line)] == $past(wr_tag))));
endmodule

// File: rtl/xlate_lookup.sv
module xlate_lookup import xlate_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_va,
  input  logic                 tlb_ld_en,
  input  logic [TLB_SET_W-1:0] tlb_ld_set,
  input  logic [TLB_WAY_W-1:0] tlb_ld_way,
  input  logic                 tlb_ld_valid,
  input  logic [TLB_TAG_W-1:0] tlb_ld_tag,
  input  logic [PPN_W-1:0]     tlb_ld_ppn,
  input  logic                 pt_ld_en,
  input  logic [VPN_W-1:0]     pt_ld_vpn,
  input  logic                 pt_ld_valid,
  input  logic [PPN_W-1:0]     pt_ld_ppn,
  input  logic                 dc_ld_en,
  input  logic [LINE_W-1:0]    dc_ld_line,
  input  logic                 dc_ld_valid,
  input  logic [CTAG_W-1:0]    dc_ld_tag,
  input  logic [BLK_BITS-1:0]  dc_ld_data,
  output logic                 rsp_valid,
  output logic                 rsp_tlb_hit,
  output logic                 rsp_fault,
  output logic [PA_W-1:0]      rsp_pa,
  output logic                 rsp_cache_hit,
  output logic [BYTE_W-1:0]    rsp_byte
);
  // reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // stage A: translation in the request cycle
  logic [VPN_W-1:0] vpn;
  logic             tlb_hit, pt_valid;
  logic [PPN_W-1:0] tlb_ppn, pt_ppn;
  logic             ins_en;
  assign vpn    = req_va[VA_W-1:PG_OFF_W];
  assign ins_en = req_valid && !tlb_hit && pt_valid;

  xlate_tlb u_tlb (
    .clk(clk), .rst_n(rst_sync_n), .lk_vpn(vpn), .lk_hit(tlb_hit), .lk_ppn(tlb_ppn),
    .ins_en(ins_en), .ins_ppn(pt_ppn),
    .ld_en(tlb_ld_en), .ld_set(tlb_ld_set), .ld_way(tlb_ld_way),
    .ld_valid(tlb_ld_valid), .ld_tag(tlb_ld_tag), .ld_ppn(tlb_ld_ppn)
  );

  xlate_ptab u_ptab (
    .clk(clk), .rst_n(rst_sync_n), .rd_vpn(vpn), .rd_valid(pt_valid), .rd_ppn(pt_ppn),
    .wr_en(pt_ld_en), .wr_vpn(pt_ld_vpn), .wr_valid(pt_ld_valid), .wr_ppn(pt_ld_ppn)
  );

  logic            a_vld_d, a_vld_q;
  logic            a_hit_d, a_hit_q;
  logic            a_flt_d, a_flt_q;
  logic [PA_W-1:0] a_pa_d, a_pa_q;

  always_comb begin
    a_vld_d = req_valid;
    a_hit_d = tlb_hit;
    a_flt_d = !tlb_hit && !pt_valid;
    a_pa_d  = a_flt_d ? '0 : {(tlb_hit ? tlb_ppn : pt_ppn), req_va[PG_OFF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) a_vld_q <= 1'b0;
    else             a_vld_q <= a_vld_d;
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      a_hit_q <= a_hit_d;
      a_flt_q <= a_flt_d;
      a_pa_q  <= a_pa_d;
    end
  end

  // stage B: cache lookup on the registered physical address
  logic              dc_hit;
  logic [BYTE_W-1:0] dc_byte;

  xlate_dcache u_dcache (
    .clk(clk), .rst_n(rst_sync_n), .rd_pa(a_pa_q), .rd_hit(dc_hit), .rd_byte(dc_byte),
    .wr_en(dc_ld_en), .wr_line(dc_ld_line), .wr_valid(dc_ld_valid),
    .wr_tag(dc_ld_tag), .wr_data(dc_ld_data)
  );

  logic              o_vld_d, o_hit_d, o_flt_d, o_ch_d;
  logic [PA_W-1:0]   o_pa_d;
  logic [BYTE_W-1:0] o_byte_d;

  always_comb begin
    o_vld_d  = a_vld_q;
    o_hit_d  = a_vld_q && a_hit_q;
    o_flt_d  = a_vld_q && a_flt_q;
    o_pa_d   = a_vld_q ? a_pa_q : '0;
    o_ch_d   = a_vld_q && !a_flt_q && dc_hit;
    o_byte_d = o_ch_d ? dc_byte : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid     <= 1'b0;
      rsp_tlb_hit   <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_pa        <= '0;
      rsp_cache_hit <= 1'b0;
      rsp_byte      <= '0;
    end else begin
      rsp_valid     <= o_vld_d;
      rsp_tlb_hit   <= o_hit_d;
      rsp_fault     <= o_flt_d;
      rsp_pa        <= o_pa_d;
      rsp_cache_hit <= o_ch_d;
      rsp_byte      <= o_byte_d;
    end
  end

  assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_fault |-> (!rsp_tlb_hit && !rsp_cache_hit && (rsp_pa == '0) && (rsp_byte == '0)));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rsp_valid |-> (!rsp_tlb_hit && !rsp_fault && !rsp_cache_hit &&
                    (rsp_pa == '0) && (rsp_byte == '0)));

  assert_hit_no_fault_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_tlb_hit |-> !rsp_fault);

  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !rsp_fault) |-> (rsp_pa[PG_OFF_W-1:0] == $past(req_va[PG_OFF_W-1:0], 2)));
endmodule

// File: tb/xlate_lookup_tb.sv
`timescale 1ns/1ps
module xlate_lookup_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [13:0] req_va;
  logic        tlb_ld_en, tlb_ld_valid, pt_ld_en, pt_ld_valid, dc_ld_en, dc_ld_valid;
  logic [1:0]  tlb_ld_set, tlb_ld_way;
  logic [5:0]  tlb_ld_tag, tlb_ld_ppn, pt_ld_ppn, dc_ld_tag;
  logic [7:0]  pt_ld_vpn;
  logic [3:0]  dc_ld_line;
  logic [31:0] dc_ld_data;
  logic        rsp_valid, rsp_tlb_hit, rsp_fault, rsp_cache_hit;
  logic [11:0] rsp_pa;
  logic [7:0]  rsp_byte;

  always #2.5 clk = ~clk;

  xlate_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .tlb_ld_en(tlb_ld_en), .tlb_ld_set(tlb_ld_set), .tlb_ld_way(tlb_ld_way),
    .tlb_ld_valid(tlb_ld_valid), .tlb_ld_tag(tlb_ld_tag), .tlb_ld_ppn(tlb_ld_ppn),
    .pt_ld_en(pt_ld_en), .pt_ld_vpn(pt_ld_vpn), .pt_ld_valid(pt_ld_valid), .pt_ld_ppn(pt_ld_ppn),
    .dc_ld_en(dc_ld_en), .dc_ld_line(dc_ld_line), .dc_ld_valid(dc_ld_valid),
    .dc_ld_tag(dc_ld_tag), .dc_ld_data(dc_ld_data),
    .rsp_valid(rsp_valid), .rsp_tlb_hit(rsp_tlb_hit), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa), .rsp_cache_hit(rsp_cache_hit), .rsp_byte(rsp_byte)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference state built from the requirements
  bit          m_tv [4][4];
  logic [5:0]  m_tt [4][4];
  logic [5:0]  m_tp [4][4];
  logic [1:0]  m_rr [4];
  bit          m_pv [256];
  logic [5:0]  m_pp [256];
  bit          m_cv [16];
  logic [5:0]  m_ct [16];
  logic [31:0] m_cd [16];

  typedef struct packed {
    logic       th;
    logic       f;
    logic [11:0] pa;
    logic       ch;
    logic [7:0] b;
  } exp_t;

  exp_t cap;

  task automatic cmp(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic model_clear();
    for (int s = 0; s < 4; s++) begin
      m_rr[s] = 2'd0;
      for (int w = 0; w < 4; w++) m_tv[s][w] = 1'b0;
    end
    for (int i = 0; i < 256; i++) m_pv[i] = 1'b0;
    for (int i = 0; i < 16; i++) m_cv[i] = 1'b0;
  endtask

  task automatic model_step(input logic [13:0] va, input bit ld, input logic [1:0] ls,
                            input logic [1:0] lw, input bit lv, input logic [5:0] lt,
                            input logic [5:0] lp, output exp_t e);
    logic [7:0] vpn;
    logic [1:0] s, vic;
    logic [5:0] t, ppn;
    logic [3:0] line;
    bit hit, found;
    vpn = va[13:6]; s = vpn[1:0]; t = vpn[7:2];
    hit = 1'b0; ppn = '0;
    for (int w = 3; w >= 0; w--)
      if (m_tv[s][w] && m_tt[s][w] == t) begin hit = 1'b1; ppn = m_tp[s][w]; end
    e.th = hit; e.f = 1'b0;
    if (!hit) begin
      if (m_pv[vpn]) begin
        ppn = m_pp[vpn];
        if (!(ld && ls == s)) begin
          found = 1'b0; vic = 2'd0;
          for (int w = 3; w >= 0; w--)
            if (!m_tv[s][w]) begin vic = 2'(w); found = 1'b1; end
          if (!found) begin vic = m_rr[s]; m_rr[s] = m_rr[s] + 2'd1; end
          m_tv[s][vic] = 1'b1; m_tt[s][vic] = t; m_tp[s][vic] = ppn;
        end
      end else e.f = 1'b1;
    end
    if (ld) begin m_tv[ls][lw] = lv; m_tt[ls][lw] = lt; m_tp[ls][lw] = lp; end
    e.pa = e.f ? 12'h000 : {ppn, va[5:0]};
    line = e.pa[5:2];
    e.ch = !e.f && m_cv[line] && (m_ct[line] == e.pa[11:6]);
    e.b  = e.ch ? m_cd[line][{e.pa[1:0], 3'b000} +: 8] : 8'h00;
  endtask

  task automatic chk_rsp(input exp_t e, input string rq);
    cmp("R9 valid pulse", {31'd0, rsp_valid}, 32'd1);
    cmp({rq, " tlb_hit"}, {31'd0, rsp_tlb_hit}, {31'd0, e.th});
    cmp("R4 fault", {31'd0, rsp_fault}, {31'd0, e.f});
    cmp("R1 pa", {20'd0, rsp_pa}, {20'd0, e.pa});
    cmp("R5 cache_hit", {31'd0, rsp_cache_hit}, {31'd0, e.ch});
    cmp("R5 byte", {24'd0, rsp_byte}, {24'd0, e.b});
    cap.th = rsp_tlb_hit; cap.f = rsp_fault; cap.pa = rsp_pa;
    cap.ch = rsp_cache_hit; cap.b = rsp_byte;
  endtask

  // starts and ends right after a falling edge
  task automatic issue_ld(input logic [13:0] va, input bit ld, input logic [1:0] ls,
                          input logic [1:0] lw, input bit lv, input logic [5:0] lt,
                          input logic [5:0] lp, input string rq);
    exp_t e;
    model_step(va, ld, ls, lw, lv, lt, lp, e);
    req_valid = 1'b1; req_va = va;
    tlb_ld_en = ld; tlb_ld_set = ls; tlb_ld_way = lw;
    tlb_ld_valid = lv; tlb_ld_tag = lt; tlb_ld_ppn = lp;
    @(negedge clk);
    req_valid = 1'b0; tlb_ld_en = 1'b0;
    cmp("R9 no early valid", {31'd0, rsp_valid}, 32'd0);
    cmp("R9 idle pa zero", {20'd0, rsp_pa}, 32'd0);
    @(negedge clk);
    chk_rsp(e, rq);
  endtask

  task automatic issue(input logic [13:0] va, input string rq);
    issue_ld(va, 1'b0, 2'd0, 2'd0, 1'b0, 6'd0, 6'd0, rq);
  endtask

  task automatic tlb_load(input logic [1:0] s, input logic [1:0] w, input bit v,
                          input logic [5:0] t, input logic [5:0] p);
    tlb_ld_en = 1'b1; tlb_ld_set = s; tlb_ld_way = w; tlb_ld_valid = v;
    tlb_ld_tag = t; tlb_ld_ppn = p;
    m_tv[s][w] = v; m_tt[s][w] = t; m_tp[s][w] = p;
    @(negedge clk);
    tlb_ld_en = 1'b0;
  endtask

  task automatic pt_load(input logic [7:0] vpn, input bit v, input logic [5:0] p);
    pt_ld_en = 1'b1; pt_ld_vpn = vpn; pt_ld_valid = v; pt_ld_ppn = p;
    m_pv[vpn] = v; m_pp[vpn] = p;
    @(negedge clk);
    pt_ld_en = 1'b0;
  endtask

  task automatic dc_load(input logic [3:0] l, input bit v, input logic [5:0] t,
                         input logic [31:0] d);
    dc_ld_en = 1'b1; dc_ld_line = l; dc_ld_valid = v; dc_ld_tag = t; dc_ld_data = d;
    m_cv[l] = v; m_ct[l] = t; m_cd[l] = d;
    @(negedge clk);
    dc_ld_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_sweep_tables();
    for (int i = 0; i < 256; i++)
      pt_load(8'(i), (i % 5) != 0, 6'((i * 7 + 3) & 63));
    for (int i = 0; i < 16; i++)
      dc_load(4'(i), (i % 3) != 2, 6'((i * 7 + 3) & 63),
              {8'(i*16+3), 8'(i*16+2), 8'(i*16+1), 8'(i*16)} ^ 32'hA55AC33C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    exp_t ea, eb;
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0;
    tlb_ld_en = 1'b0; tlb_ld_set = '0; tlb_ld_way = '0; tlb_ld_valid = 1'b0;
    tlb_ld_tag = '0; tlb_ld_ppn = '0;
    pt_ld_en = 1'b0; pt_ld_vpn = '0; pt_ld_valid = 1'b0; pt_ld_ppn = '0;
    dc_ld_en = 1'b0; dc_ld_line = '0; dc_ld_valid = 1'b0; dc_ld_tag = '0; dc_ld_data = '0;
    @(negedge clk);
    do_reset();

    // R10: reset state
    cmp("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    cmp("R10 rsp_pa", {20'd0, rsp_pa}, 32'd0);
    issue(14'h03D4, "R10");
    cmp("R10 empty tables fault", {31'd0, cap.f}, 32'd1);

    // R11: worked examples
    tlb_load(2'd3, 2'd1, 1'b1, 6'h03, 6'h0D);
    pt_load(8'h00, 1'b1, 6'h28);
    dc_load(4'd5, 1'b1, 6'h0D, 32'h1DF07236);
    dc_load(4'd8, 1'b1, 6'h24, 32'h8951003A);
    issue(14'h03D4, "R2");
    cmp("R11 hit", {31'd0, cap.th}, 32'd1);
    cmp("R11 pa", {20'd0, cap.pa}, 32'h354);
    cmp("R11 byte", {24'd0, cap.b}, 32'h36);
    issue(14'h0020, "R3");
    cmp("R11 miss", {31'd0, cap.th}, 32'd0);
    cmp("R11 no fault", {31'd0, cap.f}, 32'd0);
    cmp("R11 pa2", {20'd0, cap.pa}, 32'hA20);
    cmp("R11 cache miss", {31'd0, cap.ch}, 32'd0);
    issue(14'h0023, "R6");
    cmp("R6 installed hit", {31'd0, cap.th}, 32'd1);

    // R6/R9: back-to-back requests to one page, second already hits
    pt_load(8'h11, 1'b1, 6'h05);
    model_step({8'h11, 6'h04}, 1'b0, 2'd0, 2'd0, 1'b0, 6'd0, 6'd0, ea);
    model_step({8'h11, 6'h09}, 1'b0, 2'd0, 2'd0, 1'b0, 6'd0, 6'd0, eb);
    req_valid = 1'b1; req_va = {8'h11, 6'h04};
    @(negedge clk);
    req_va = {8'h11, 6'h09};
    cmp("R9 no early valid", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk_rsp(ea, "R6");
    cmp("R6 first misses", {31'd0, cap.th}, 32'd0);
    @(negedge clk);
    chk_rsp(eb, "R6");
    cmp("R6 next-cycle hit", {31'd0, cap.th}, 32'd1);
    @(negedge clk);
    cmp("R9 pulse ends", {31'd0, rsp_valid}, 32'd0);

    // R6/R7/R4 directed on set 1
    do_reset();
    load_sweep_tables();
    issue({8'd1, 6'h2D}, "R6");
    issue({8'd9, 6'h2D}, "R6");
    issue({8'd13, 6'h2D}, "R6");
    issue({8'd17, 6'h2D}, "R6");
    issue({8'd21, 6'h2D}, "R7");
    issue({8'd1, 6'h2D}, "R7");
    cmp("R7 way0 evicted", {31'd0, cap.th}, 32'd0);
    issue({8'd13, 6'h2D}, "R7");
    cmp("R7 way2 kept", {31'd0, cap.th}, 32'd1);
    issue({8'd9, 6'h2D}, "R7");
    cmp("R7 way1 evicted", {31'd0, cap.th}, 32'd0);
    issue({8'd5, 6'h2D}, "R4");
    cmp("R4 fault", {31'd0, cap.f}, 32'd1);
    issue({8'd5, 6'h2D}, "R4");
    cmp("R4 still faults", {31'd0, cap.f}, 32'd1);

    // sweeps over every page, two offset patterns
    for (int v = 0; v < 256; v++)
      issue({8'(v), 6'(v & 15) << 2 | 6'((v >> 4) & 3)}, "R2");
    for (int v = 255; v >= 0; v--)
      issue({8'(v), 6'(v * 13)}, "R3");

    // R8: install and load-port write on the same edge
    do_reset();
    load_sweep_tables();
    issue_ld({8'd6, 6'h11}, 1'b1, 2'd2, 2'd3, 1'b1, 6'd9, 6'd5, "R8");
    issue({8'd38, 6'h07}, "R8");
    cmp("R8 written entry hits", {31'd0, cap.th}, 32'd1);
    cmp("R8 written frame", {20'd0, cap.pa}, {20'd0, 6'd5, 6'h07});
    issue({8'd6, 6'h11}, "R8");
    cmp("R8 install dropped", {31'd0, cap.th}, 32'd0);
    issue_ld({8'd7, 6'h01}, 1'b1, 2'd0, 2'd0, 1'b1, 6'd2, 6'd1, "R8");
    issue({8'd7, 6'h01}, "R8");
    cmp("R8 other-set install kept", {31'd0, cap.th}, 32'd1);
    issue({8'd8, 6'h01}, "R8");
    cmp("R8 other-set write kept", {31'd0, cap.th}, 32'd1);

    summary();
    $finish;
  end
endmodule